// File: doc/BRIEF.md
# GNSS Correlator Tracking Channel

This block is one tracking channel of a satellite-navigation correlator. In every cycle it takes one quantised sample from a bank of parallel source lanes and picks one lane through a configuration field. It removes the carrier from that sample using a coarse five-level cosine/sine replica. The replica comes from a phase-accumulator oscillator that advances once for each accepted sample. The channel then correlates the wiped sample against early, prompt and late copies of the spreading code, which an external code generator supplies one chip at a time.

Six running sums are kept: in-phase and quadrature for each of the three code taps. When the epoch strobe marks the end of a code period, the sums move into holding registers and the running sums restart from zero. The oscillator phase is captured at the same moment. A ready flag then stays raised until software acknowledges the readout. Software reads the holding registers through a small select/data port and closes its tracking loops from them. The same path serves when the channel is used to despread a data signal.

The sample stream uses a valid/ready pair. The channel never applies back-pressure: `s_ready` is high out of reset, and a sample is consumed in every cycle in which `s_valid` is high. All other pins are plain strobes and levels.

Top module: `corr_track_channel`

## Requirements
- R1: After reset, `dump_ready` is 0, every readout select returns 0 and `s_ready` is 1.
- R2: `s_ready` stays 1. Lane k occupies `s_data[2k+1:2k]`. Configuration word 0 bits [3:0] choose the lane, and a selection of NUM_SRC or more makes every sample contribute nothing.
- R3: Each lane carries a sign bit (bit 1, set means −1) and a non-zero bit (bit 0). Configuration word 0 bit 8 set selects three-level mode, where a sample with bit 0 clear adds nothing. With bit 8 clear (two-level mode), bit 0 is ignored and every sample is ±1.
- R4: The 32-bit carrier phase is 0 after reset and advances by the frequency word (configuration word 1) once per accepted sample. Each sample is wiped with the phase held before its own advance.
- R5: The replica is indexed by phase bits [31:29]. Index 0..7 gives cosine +2,+1,0,−1,−2,−1,0,+1 and sine 0,+1,+2,+1,0,−1,−2,−1. The in-phase product is sample×cosine and the quadrature product is sample×sine.
- R6: On `code_en` the chip in `code_chip` becomes the early tap, the old early tap becomes prompt and the old prompt becomes late. Chip bit 1 means −1 and 0 means +1. All taps are 0 after reset, and a shift applies from the next cycle's sample.
- R7: Each accepted sample adds the in-phase product times each tap's chip to the matching in-phase sum, and the quadrature product times the chip to the matching quadrature sum (ACC_W-bit two's complement).
- R8: `epoch` copies the six sums into the holding registers and clears the sums in the same cycle. A sample accepted in that cycle counts toward the new epoch only.
- R9: `epoch` captures the phase held in that cycle (before any advance in that cycle). `rd_sel` 6 returns it.
- R10: `dump_ready` rises the cycle after `epoch` and falls the cycle after `rd_ack`. When both arrive together, the flag stays set.
- R11: `rd_sel` 0..5 returns in-phase early, prompt, late and then quadrature early, prompt, late, each sign-extended to 32 bits. `rd_sel` 7 returns 0.
- R12: A configuration write takes effect from the following cycle. A sample in the write cycle uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample lanes carry a sample this cycle |
| s_ready | output | 1 | Channel accepts the sample (always high) |
| s_data | input | 2*NUM_SRC | Packed sample lanes, 2 bits each |
| code_en | input | 1 | Shift the next chip into the code taps |
| code_chip | input | 1 | Next code chip (1 = −1) |
| epoch | input | 1 | End of code epoch: dump and clear |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = lane select/mode, 1 = frequency word |
| cfg_wdata | input | 32 | Configuration write data |
| rd_sel | input | 3 | Readout register select |
| rd_data | output | 32 | Selected readout value |
| rd_ack | input | 1 | Software has taken the dump |
| dump_ready | output | 1 | A new dump is waiting |

## Verification
The assertions assume that the epoch strobe and the readout acknowledge are single-cycle pulses driven from the same clock. They also assume that lane bits never take unknown values while `s_valid` is high. The tap-shift checks assume that `code_chip` is defined whenever `code_en` is high. The bench drives every input on the falling edge, so all inputs are settled and known at each rising edge. It pulses `epoch`, `rd_ack` and `code_en` for one cycle each, and it draws lane values from 2-bit random numbers, so no lane is ever undefined.

// File: rtl/corr_pkg.sv
package corr_pkg;

  localparam int PHASE_W = 32;
  localparam int CARR_W  = 3;
  localparam int PROD_W  = 4;
  localparam int NUM_TAP = 3;

  typedef logic signed [CARR_W-1:0] carr_t;
  typedef logic signed [PROD_W-1:0] prod_t;

  function automatic carr_t carr_cos(input logic [2:0] idx);
    case (idx)
      3'd0: return  3'sd2;
      3'd1: return  3'sd1;
      3'd2: return  3'sd0;
      3'd3: return -3'sd1;
      3'd4: return -3'sd2;
      3'd5: return -3'sd1;
      3'd6: return  3'sd0;
      default: return 3'sd1;
    endcase
  endfunction

  function automatic carr_t carr_sin(input logic [2:0] idx);
    return carr_cos(idx - 3'd2);
  endfunction

endpackage

// File: rtl/corr_src_select.sv
module corr_src_select #(
  parameter int NUM_SRC = 10,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*NUM_SRC-1:0] lanes,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 three_level,
  output logic                 samp_neg,
  output logic                 samp_nz
);

  logic [1:0] picked;
  logic       in_range;

  always_comb begin
    picked   = 2'b00;
    in_range = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel == SEL_W'(k)) begin
        picked   = lanes[2*k +: 2];
        in_range = 1'b1;
      end
    end
  end

  assign samp_neg = picked[1];
  assign samp_nz  = in_range & (picked[0] | ~three_level);

  // R2: an out-of-range lane select never yields a live sample
  assert_bad_sel_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SEL_W'(NUM_SRC)) |-> !samp_nz);

  // R3: in two-level mode a valid lane always gives a non-zero sample
  assert_two_level_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!three_level && sel < SEL_W'(NUM_SRC)) |-> samp_nz);

endmodule

// File: rtl/corr_carrier_nco.sv
module corr_carrier_nco
  import corr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic [PHASE_W-1:0] fcw,
  output logic [PHASE_W-1:0] phase,
  output carr_t              cos_o,
  output carr_t              sin_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (advance) phase <= phase + fcw;
  end

  assign cos_o = carr_cos(phase[PHASE_W-1 -: 3]);
  assign sin_o = carr_sin(phase[PHASE_W-1 -: 3]);

  // R4: phase only moves on an accepted sample
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(phase));

  // R5: replica stays within the five permitted levels
  assert_replica_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_o >= -3'sd2) && (cos_o <= 3'sd2) && (sin_o >= -3'sd2) && (sin_o <= 3'sd2));

endmodule

// File: rtl/corr_code_taps.sv
module corr_code_taps
  import corr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               code_en,
  input  logic               code_chip,
  output logic [NUM_TAP-1:0] taps
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       taps <= '0;
    else if (code_en) taps <= {taps[NUM_TAP-2:0], code_chip};
  end

  // R6: taps hold between chip strobes
  assert_taps_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !code_en |=> $stable(taps));

  // R6: a strobe moves early into prompt and prompt into late
  assert_taps_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_en |=> (taps[NUM_TAP-1:1] == $past(taps[NUM_TAP-2:0])));

endmodule

// File: rtl/corr_accum_bank.sv
module corr_accum_bank
  import corr_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int RD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic               samp_neg,
  input  logic               samp_nz,
  input  carr_t              cos_i,
  input  carr_t              sin_i,
  input  logic [NUM_TAP-1:0] taps,
  input  logic               epoch,
  input  logic               rd_ack,
  input  logic [PHASE_W-1:0] phase,
  input  logic [2:0]         rd_sel,
  output logic [RD_W-1:0]    rd_data,
  output logic               dump_ready
);

  localparam int EXT_W = ACC_W - PROD_W;
  localparam int RX_W  = RD_W - ACC_W;

  logic signed [ACC_W-1:0] acc_i  [NUM_TAP];
  logic signed [ACC_W-1:0] acc_q  [NUM_TAP];
  logic signed [ACC_W-1:0] dump_i [NUM_TAP];
  logic signed [ACC_W-1:0] dump_q [NUM_TAP];
  logic [PHASE_W-1:0]      snap;

  prod_t wipe_i, wipe_q;
  prod_t add_i [NUM_TAP];
  prod_t add_q [NUM_TAP];

  always_comb begin
    prod_t c4, s4;
    c4 = {cos_i[CARR_W-1], cos_i};
    s4 = {sin_i[CARR_W-1], sin_i};
    if (!valid || !samp_nz) begin
      wipe_i = '0;
      wipe_q = '0;
    end else if (samp_neg) begin
      wipe_i = -c4;
      wipe_q = -s4;
    end else begin
      wipe_i = c4;
      wipe_q = s4;
    end
  end

  for (genvar g = 0; g < NUM_TAP; g++) begin : g_tap
    assign add_i[g] = taps[g] ? -wipe_i : wipe_i;
    assign add_q[g] = taps[g] ? -wipe_q : wipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_i[g]  <= '0;
        acc_q[g]  <= '0;
        dump_i[g] <= '0;
        dump_q[g] <= '0;
      end else begin
        acc_i[g] <= (epoch ? '0 : acc_i[g]) + {{EXT_W{add_i[g][PROD_W-1]}}, add_i[g]};
        acc_q[g] <= (epoch ? '0 : acc_q[g]) + {{EXT_W{add_q[g][PROD_W-1]}}, add_q[g]};
        if (epoch) begin
          dump_i[g] <= acc_i[g];
          dump_q[g] <= acc_q[g];
        end
      end
    end

    // R8: holding registers change only at an epoch
    assert_dump_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !epoch |=> ($stable(dump_i[g]) && $stable(dump_q[g])));

    // R8: running sums restart from zero when no sample shares the epoch cycle
    assert_sum_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (epoch && !valid) |=> (acc_i[g] == '0 && acc_q[g] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap       <= '0;
      dump_ready <= 1'b0;
    end else begin
      if (epoch) snap <= phase;
      if (epoch)       dump_ready <= 1'b1;
      else if (rd_ack) dump_ready <= 1'b0;
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0: rd_data = {{RX_W{dump_i[0][ACC_W-1]}}, dump_i[0]};
      3'd1: rd_data = {{RX_W{dump_i[1][ACC_W-1]}}, dump_i[1]};
      3'd2: rd_data = {{RX_W{dump_i[2][ACC_W-1]}}, dump_i[2]};
      3'd3: rd_data = {{RX_W{dump_q[0][ACC_W-1]}}, dump_q[0]};
      3'd4: rd_data = {{RX_W{dump_q[1][ACC_W-1]}}, dump_q[1]};
      3'd5: rd_data = {{RX_W{dump_q[2][ACC_W-1]}}, dump_q[2]};
      3'd6: rd_data = RD_W'(snap);
      default: rd_data = '0;
    endcase
  end

  // R10: flag is up the cycle after an epoch
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |=> dump_ready);

  // R10: acknowledge without epoch drops the flag
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !epoch) |=> !dump_ready);

  // R9: snapshot moves only at an epoch
  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch |=> $stable(snap));

endmodule

// File: rtl/corr_track_channel.sv
module corr_track_channel
  import corr_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int ACC_W   = 24,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LANE_W = 2 * NUM_SRC,
  localparam int RD_W   = PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [LANE_W-1:0]  s_data,
  input  logic               code_en,
  input  logic               code_chip,
  input  logic               epoch,
  input  logic               cfg_we,
  input  logic               cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic [2:0]         rd_sel,
  output logic [RD_W-1:0]    rd_data,
  input  logic               rd_ack,
  output logic               dump_ready
);

  localparam int MODE_BIT = 8;

  logic [SEL_W-1:0]   src_sel;
  logic               three_level;
  logic [PHASE_W-1:0] fcw;
  logic               samp_neg, samp_nz;
  logic [PHASE_W-1:0] phase;
  carr_t              cos_v, sin_v;
  logic [NUM_TAP-1:0] taps;
  logic               take;

  assign s_ready = 1'b1;
  assign take    = s_valid & s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel     <= '0;
      three_level <= 1'b0;
      fcw         <= '0;
    end else if (cfg_we) begin
      if (cfg_addr) begin
        fcw <= cfg_wdata;
      end else begin
        src_sel     <= cfg_wdata[SEL_W-1:0];
        three_level <= cfg_wdata[MODE_BIT];
      end
    end
  end

  corr_src_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .lanes       (s_data),
    .sel         (src_sel),
    .three_level (three_level),
    .samp_neg    (samp_neg),
    .samp_nz     (samp_nz)
  );

  corr_carrier_nco u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (take),
    .fcw     (fcw),
    .phase   (phase),
    .cos_o   (cos_v),
    .sin_o   (sin_v)
  );

  corr_code_taps u_taps (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_en   (code_en),
    .code_chip (code_chip),
    .taps      (taps)
  );

  corr_accum_bank #(.ACC_W(ACC_W), .RD_W(RD_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (take),
    .samp_neg   (samp_neg),
    .samp_nz    (samp_nz),
    .cos_i      (cos_v),
    .sin_i      (sin_v),
    .taps       (taps),
    .epoch      (epoch),
    .rd_ack     (rd_ack),
    .phase      (phase),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .dump_ready (dump_ready)
  );

  // R2: the stream is never back-pressured
  assert_always_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready);

  // R12: configuration holds when not written
  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(fcw) && $stable(src_sel) && $stable(three_level)));

endmodule

// File: tb/test_corr_track_channel.sv
`timescale 1ns/1ps
module test_corr_track_channel;

  localparam int NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [2*NS-1:0] s_data = '0;
  logic        code_en = 1'b0, code_chip = 1'b0, epoch = 1'b0;
  logic        cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        rd_ack = 1'b0, dump_ready;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  int          m_acc [6];
  int          m_dump [6];
  logic [31:0] m_phase = '0, m_snap = '0, m_fcw = '0;
  logic [2:0]  m_taps = '0;
  int          m_sel = 0;
  bit          m_three = 0, m_rdy = 0;
  logic [1:0]  lane [NS];

  always #2.5 clk = ~clk;

  corr_track_channel #(.NUM_SRC(NS)) i_corr_track_channel (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .code_en(code_en), .code_chip(code_chip), .epoch(epoch), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_ack(rd_ack), .dump_ready(dump_ready));

  function automatic int cosv(logic [2:0] i);
    int t [8] = '{2, 1, 0, -1, -2, -1, 0, 1};
    return t[i];
  endfunction
  function automatic int sinv(logic [2:0] i);
    int t [8] = '{0, 1, 2, 1, 0, -1, -2, -1};
    return t[i];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; inputs applied after a falling edge
  task automatic step(bit v, bit ce, bit cb, bit ep, bit ack,
                      bit we = 0, bit addr = 0, logic [31:0] wd = '0);
    int s;
    s_valid = v; code_en = ce; code_chip = cb; epoch = ep; rd_ack = ack;
    cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    for (int k = 0; k < NS; k++) s_data[2*k +: 2] = lane[k];
    @(posedge clk);
    if (ep) begin
      for (int k = 0; k < 6; k++) begin m_dump[k] = m_acc[k]; m_acc[k] = 0; end
      m_snap = m_phase; m_rdy = 1;
    end else if (ack) m_rdy = 0;
    if (v) begin
      if (m_sel >= NS) s = 0;
      else if (m_three && !lane[m_sel][0]) s = 0;
      else s = lane[m_sel][1] ? -1 : 1;
      for (int k = 0; k < 3; k++) begin
        int cv;
        cv = m_taps[k] ? -1 : 1;
        m_acc[k]   += s * cosv(m_phase[31:29]) * cv;
        m_acc[3+k] += s * sinv(m_phase[31:29]) * cv;
      end
      m_phase += m_fcw;
    end
    if (ce) m_taps = {m_taps[1:0], cb};
    if (we) begin
      if (addr) m_fcw = wd;
      else begin m_sel = int'(wd[3:0]); m_three = wd[8]; end
    end
    @(negedge clk);
    s_valid = 0; code_en = 0; epoch = 0; rd_ack = 0; cfg_we = 0;
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < 7; k++) begin
      rd_sel = 3'(k);
      #1;
      check(req, rd_data, (k < 6) ? 32'(m_dump[k]) : m_snap);
    end
    check({req, "/R10 flag"}, {31'd0, dump_ready}, {31'd0, m_rdy});
  endtask

  task automatic randomize_lanes();
    for (int k = 0; k < NS; k++) lane[k] = 2'($urandom);
  endtask

  task automatic burst(int n, bit codes);
    for (int i = 0; i < n; i++) begin
      randomize_lanes();
      step(($urandom % 4) != 0, codes && (($urandom % 3) == 0), 1'($urandom), 0, 0);
    end
  endtask

  task automatic test_reset();
    rd_sel = 3'd7;
    #1;
    check("R11 sel7 zero", rd_data, 32'd0);
    check("R1 ready", {31'd0, s_ready}, 32'd1);
    read_all("R1 reset");
  endtask

  task automatic test_two_level();
    step(0, 0, 0, 0, 0, 1, 0, 32'h3);
    step(0, 0, 0, 1, 1);
    burst(25, 0);
    step(0, 0, 0, 1, 0);
    read_all("R2/R3/R7 two-level");
    check("R2 ready", {31'd0, s_ready}, 32'd1);
  endtask

  task automatic test_three_level();
    step(0, 0, 0, 0, 0, 1, 0, 32'h105);
    step(0, 0, 0, 1, 1);
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < NS; k++) lane[k] = 2'b00;
      step(1, 0, 0, 0, 0);
    end
    step(0, 0, 0, 1, 0);
    read_all("R3 zero samples");
    burst(30, 0);
    step(0, 0, 0, 1, 1);
    read_all("R3 three-level mix");
  endtask

  task automatic test_source_select();
    step(0, 0, 0, 0, 0, 1, 0, 32'h9);
    step(0, 0, 0, 1, 1);
    burst(20, 0);
    step(0, 0, 0, 1, 1);
    read_all("R2 lane 9");
    step(0, 0, 0, 0, 0, 1, 0, 32'hC);
    burst(20, 0);
    step(0, 0, 0, 1, 1);
    read_all("R2 out-of-range select");
  endtask

  task automatic test_nco();
    step(0, 0, 0, 0, 0, 1, 0, 32'h0);
    step(0, 0, 0, 0, 0, 1, 1, 32'h2000_0000);
    step(0, 0, 0, 1, 1);
    burst(40, 0);
    step(0, 0, 0, 1, 1);
    read_all("R4/R5/R9 octant steps");
    step(0, 0, 0, 0, 0, 1, 1, 32'h0765_4321);
    burst(40, 0);
    step(0, 0, 0, 1, 1);
    read_all("R4/R9 odd frequency");
  endtask

  task automatic test_code_taps();
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < NS; k++) lane[k] = 2'b00;
      step(1, 1, (i % 2) == 0, 0, 0);
    end
    step(0, 0, 0, 1, 1);
    burst(40, 1);
    step(0, 0, 0, 1, 1);
    read_all("R6/R7 code taps");
  endtask

  task automatic test_epoch_overlap();
    randomize_lanes();
    step(1, 0, 0, 1, 1);
    randomize_lanes();
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1);
    read_all("R8 sample in epoch cycle");
  endtask

  task automatic test_dump_flag();
    step(0, 0, 0, 1, 0);
    check("R10 set", {31'd0, dump_ready}, 32'd1);
    step(0, 0, 0, 0, 1);
    check("R10 ack clears", {31'd0, dump_ready}, 32'd0);
    step(0, 0, 0, 1, 1);
    check("R10 epoch wins", {31'd0, dump_ready}, 32'd1);
    step(0, 0, 0, 0, 0);
    check("R10 holds", {31'd0, dump_ready}, 32'd1);
  endtask

  task automatic test_cfg_timing();
    step(0, 0, 0, 0, 0, 1, 0, 32'h1);
    step(0, 0, 0, 0, 0, 1, 1, 32'h0);
    step(0, 0, 0, 1, 1);
    for (int k = 0; k < NS; k++) lane[k] = 2'b00;
    lane[1] = 2'b10;
    lane[2] = 2'b01;
    // sample in the write cycle still uses lane 1
    step(1, 0, 0, 0, 0, 1, 0, 32'h2);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1);
    read_all("R12 write latency");
  endtask

  initial begin
    for (int k = 0; k < 6; k++) begin m_acc[k] = 0; m_dump[k] = 0; end
    for (int k = 0; k < NS; k++) lane[k] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_two_level();
    test_three_level();
    test_source_select();
    test_nco();
    test_code_taps();
    test_epoch_overlap();
    test_dump_flag();
    test_cfg_timing();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule